// File: doc/BRIEF.md
# Jump-Gated Special Event Dispatcher

This unit decides when a processor may start handling a special event and which event it starts. It watches four kinds of request: a reset request, an exception, a non-maskable interrupt and 32 maskable interrupt sources. The reset request is honoured in any cycle. The other three are honoured only in a cycle where an interruptible jump executes and is actually taken. Inside a straight run of code no event can therefore start. Nested handling follows the same rule: a new event may start while a handler is running, but again only at a taken interruptible jump.

When an event is accepted, the unit raises a one-cycle take strobe for that acceptance. With the strobe it gives the event class, the interrupt source number and the address to dispatch to. The maskable sources are served by a small register block:

- a pending set, which an incoming request pulse or a write-one-to-set register can mark;
- a write-one-to-clear register;
- an enable mask;
- an exception vector register;
- one vector register per source.

Software clears a pending bit itself. Acceptance never clears it.

Top module: `jump_event_gate`

## Requirements
- R1: While `resetReq` is 1 at a clock edge, the next cycle shows `takeEvt`=1, `evtClass`=0 and `evtVector`=RESET_VEC, whatever the jump inputs are.
- R2: An exception, non-maskable or maskable event is accepted only when, at the same edge, `jmpValid`=1, `jmpKind` is 1 (jump-if-true), 2 (jump-if-false) or 3 (unconditional), and `jmpTaken`=1.
- R3: A jump with `jmpKind`=0 (plain, non-interruptible) or with `jmpTaken`=0 starts no event, even when events are waiting; `takeEvt` stays 0 in the next cycle.
- R4: When several events are eligible at once, reset (class 0) wins over exception (class 1), which wins over the non-maskable interrupt (class 2), which wins over a maskable interrupt (class 3).
- R5: An accepted exception dispatches to the value of the exception vector register, at word index 0.
- R6: An accepted non-maskable interrupt dispatches to the parameter NMI_VEC.
- R7: A maskable interrupt is eligible when its pending bit is set and its mask bit is 1 (1 enables). The lowest-numbered eligible source wins. `evtSrc` gives its number, and `evtVector` gives its vector register, at word index 32+source. Register writes made in the same cycle as an acceptance take effect after it.
- R8: The pending bit for source i is set by `irqIn[i]`=1, or by writing 1 to bit i of the set register at word index 2. The pending set reads back at word index 1, and the mask reads back and is written at word index 4.
- R9: Writing 1 to bit i of the clear register, at word index 3, clears pending bit i. A 0 bit has no effect. A request for the same source in the same cycle wins over the clear.
- R10: Acceptance does not clear the pending bit. `takeEvt` is high for exactly the cycle after each accepting edge. In cycles without a take, `evtClass`, `evtSrc` and `evtVector` are 0.
- R11: After `rstN` is low, `takeEvt` is 0 and the pending, mask, exception vector and source vector registers all read 0.
- R12: Acceptance repeats at every qualifying jump, including taken jumps in consecutive cycles, so a nested event can start while a handler is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| resetReq | input | 1 | Reset event request, honoured in any cycle |
| excReq | input | 1 | Exception request |
| nmiReq | input | 1 | Non-maskable interrupt request |
| irqIn | input | N_SRC | Per-source request pulses that set pending bits |
| jmpValid | input | 1 | A jump executes this cycle |
| jmpKind | input | 2 | Jump kind: 0 plain, 1 if-true, 2 if-false, 3 unconditional |
| jmpTaken | input | 1 | The jump is taken |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word index for writes and reads |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for `regAddr`, combinational |
| takeEvt | output | 1 | One-cycle acceptance strobe |
| evtClass | output | 2 | Accepted class: 0 reset, 1 exception, 2 NMI, 3 interrupt |
| evtSrc | output | SRC_W | Winning maskable source number |
| evtVector | output | DATA_W | Dispatch address |

## Verification
Two functions can fall in the same cycle: a register write that changes the state an acceptance reads, and that acceptance. The cases are a pending-bit clear or a vector write made in the same cycle that the source is accepted, and a request pulse arriving in the same cycle as a clear for that source. The bench drives each collision on purpose and also lets random traffic produce it. Its behavioural model applies the rule that the decision uses the state from before the edge while the writes land after it, and it compares the outputs and the read port against the model on every clock.

// File: rtl/jeg_pkg.sv
package jeg_pkg;
  typedef enum logic [1:0] {
    EV_RESET = 2'd0,
    EV_EXC   = 2'd1,
    EV_NMI   = 2'd2,
    EV_INT   = 2'd3
  } evClass_e;

  localparam int REG_EXCVEC = 0;
  localparam int REG_PEND   = 1;
  localparam int REG_SET    = 2;
  localparam int REG_CLR    = 3;
  localparam int REG_MASK   = 4;
  localparam int VEC_BASE   = 32;

  typedef struct packed {
    logic     wrExcVec;
    logic     wrSet;
    logic     wrClr;
    logic     wrMask;
    logic     wrVec;
    logic     take;
    evClass_e cls;
  } ctrlStrb_t;
endpackage

// File: rtl/jeg_ctrl.sv
module jeg_ctrl
  import jeg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_SRC  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              excReq,
  input  logic              nmiReq,
  input  logic              jmpValid,
  input  logic [1:0]        jmpKind,
  input  logic              jmpTaken,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              irqAny,
  output ctrlStrb_t         strb,
  output logic              takeEvt,
  output evClass_e          evtClass
);
  logic windowOpen;

  // only a taken interruptible jump opens the window
  assign windowOpen = jmpValid && (jmpKind != 2'd0) && jmpTaken;

  always_comb begin
    strb = '0;
    strb.cls = EV_RESET;
    if (regWrEn) begin
      strb.wrExcVec = (int'(regAddr) == REG_EXCVEC);
      strb.wrSet    = (int'(regAddr) == REG_SET);
      strb.wrClr    = (int'(regAddr) == REG_CLR);
      strb.wrMask   = (int'(regAddr) == REG_MASK);
      strb.wrVec    = (int'(regAddr) >= VEC_BASE) && (int'(regAddr) < VEC_BASE + N_SRC);
    end
    if (resetReq) begin
      strb.take = 1'b1;
      strb.cls  = EV_RESET;
    end else if (windowOpen && excReq) begin
      strb.take = 1'b1;
      strb.cls  = EV_EXC;
    end else if (windowOpen && nmiReq) begin
      strb.take = 1'b1;
      strb.cls  = EV_NMI;
    end else if (windowOpen && irqAny) begin
      strb.take = 1'b1;
      strb.cls  = EV_INT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeEvt  <= 1'b0;
      evtClass <= EV_RESET;
    end else begin
      takeEvt  <= strb.take;
      evtClass <= strb.take ? strb.cls : EV_RESET;
    end
  end
endmodule

// File: rtl/jeg_datapath.sv
module jeg_datapath
  import jeg_pkg::*;
#(
  parameter int          N_SRC     = 32,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 6,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [31:0] NMI_VEC   = 32'h0000_0200,
  localparam int         SRC_W     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [N_SRC-1:0]  irqIn,
  output logic              irqAny,
  output logic [DATA_W-1:0] regRdData,
  output logic [SRC_W-1:0]  evtSrc,
  output logic [DATA_W-1:0] evtVector
);
  logic [DATA_W-1:0] excVecQ;
  logic [N_SRC-1:0]  maskQ;
  logic [N_SRC-1:0]  pendQ;
  logic [N_SRC-1:0]  activeSrc;
  logic [N_SRC-1:0]  setBits;
  logic [N_SRC-1:0]  clrBits;
  logic [SRC_W-1:0]  winSrc;
  logic [DATA_W-1:0] vecArr [N_SRC];

  // one vector register per maskable source
  for (genvar g = 0; g < N_SRC; g++) begin : gVec
    logic [DATA_W-1:0] vecR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vecR <= '0;
      else if (strb.wrVec && (int'(regAddr) == VEC_BASE + g)) vecR <= regWrData;
    end
    assign vecArr[g] = vecR;
  end

  assign setBits = strb.wrSet ? regWrData[N_SRC-1:0] : '0;
  assign clrBits = strb.wrClr ? regWrData[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excVecQ <= '0;
      maskQ   <= '0;
      pendQ   <= '0;
    end else begin
      if (strb.wrExcVec) excVecQ <= regWrData;
      if (strb.wrMask)   maskQ   <= regWrData[N_SRC-1:0];
      // requests override a simultaneous clear
      pendQ <= (pendQ & ~clrBits) | irqIn | setBits;
    end
  end

  assign activeSrc = pendQ & maskQ;
  assign irqAny    = |activeSrc;

  // lowest-numbered active source wins
  always_comb begin
    winSrc = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (activeSrc[i]) winSrc = SRC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtSrc    <= '0;
      evtVector <= '0;
    end else if (strb.take) begin
      evtSrc <= (strb.cls == EV_INT) ? winSrc : '0;
      unique case (strb.cls)
        EV_RESET: evtVector <= DATA_W'(RESET_VEC);
        EV_EXC:   evtVector <= excVecQ;
        EV_NMI:   evtVector <= DATA_W'(NMI_VEC);
        default:  evtVector <= vecArr[winSrc];
      endcase
    end else begin
      evtSrc    <= '0;
      evtVector <= '0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (int'(regAddr) == REG_EXCVEC) regRdData = excVecQ;
    if (int'(regAddr) == REG_PEND)   regRdData = DATA_W'(pendQ);
    if (int'(regAddr) == REG_MASK)   regRdData = DATA_W'(maskQ);
    for (int i = 0; i < N_SRC; i++) begin
      if (int'(regAddr) == VEC_BASE + i) regRdData = vecArr[i];
    end
  end
endmodule

// File: rtl/jump_event_gate.sv
module jump_event_gate
  import jeg_pkg::*;
#(
  parameter int          N_SRC     = 32,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 6,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [31:0] NMI_VEC   = 32'h0000_0200,
  localparam int         SRC_W     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              excReq,
  input  logic              nmiReq,
  input  logic [N_SRC-1:0]  irqIn,
  input  logic              jmpValid,
  input  logic [1:0]        jmpKind,
  input  logic              jmpTaken,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              takeEvt,
  output logic [1:0]        evtClass,
  output logic [SRC_W-1:0]  evtSrc,
  output logic [DATA_W-1:0] evtVector
);
  ctrlStrb_t strb;
  evClass_e  classQ;
  logic      irqAny;

  jeg_ctrl #(.ADDR_W(ADDR_W), .N_SRC(N_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .excReq(excReq),
    .nmiReq(nmiReq), .jmpValid(jmpValid), .jmpKind(jmpKind),
    .jmpTaken(jmpTaken), .regWrEn(regWrEn), .regAddr(regAddr),
    .irqAny(irqAny), .strb(strb), .takeEvt(takeEvt), .evtClass(classQ)
  );

  jeg_datapath #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .RESET_VEC(RESET_VEC), .NMI_VEC(NMI_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .irqIn(irqIn), .irqAny(irqAny),
    .regRdData(regRdData), .evtSrc(evtSrc), .evtVector(evtVector)
  );

  assign evtClass = classQ;
endmodule

// File: rtl/jeg_checks.sv
module jeg_checks #(
  parameter int SRC_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              resetReq,
  input logic              excReq,
  input logic              nmiReq,
  input logic              jmpValid,
  input logic [1:0]        jmpKind,
  input logic              jmpTaken,
  input logic              takeEvt,
  input logic [1:0]        evtClass,
  input logic [SRC_W-1:0]  evtSrc,
  input logic [DATA_W-1:0] evtVector
);
  logic winOpen;
  assign winOpen = jmpValid && (jmpKind != 2'd0) && jmpTaken;

  assert_reset_any_R1: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (takeEvt && evtClass == 2'd0));

  assert_jump_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (takeEvt && evtClass != 2'd0) |-> $past(winOpen));

  assert_untaken_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !winOpen) |=> !takeEvt);

  assert_exc_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && winOpen && excReq) |=> (takeEvt && evtClass == 2'd1));

  assert_nmi_next_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && winOpen && !excReq && nmiReq) |=> (takeEvt && evtClass == 2'd2));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !takeEvt |-> (evtClass == 2'd0 && evtSrc == '0 && evtVector == '0));
endmodule

bind jump_event_gate jeg_checks #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .excReq(excReq),
  .nmiReq(nmiReq), .jmpValid(jmpValid), .jmpKind(jmpKind),
  .jmpTaken(jmpTaken), .takeEvt(takeEvt), .evtClass(evtClass),
  .evtSrc(evtSrc), .evtVector(evtVector)
);

// File: tb/jump_event_gate_test.sv
`timescale 1ns/1ps
module jump_event_gate_test;
  localparam logic [31:0] RST_V = 32'h0000_0100;
  localparam logic [31:0] NMI_V = 32'h0000_0200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 0, excReq = 0, nmiReq = 0;
  logic [31:0] irqIn = '0;
  logic jmpValid = 0, jmpTaken = 0;
  logic [1:0] jmpKind = '0;
  logic regWrEn = 0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic takeEvt;
  logic [1:0] evtClass;
  logic [4:0] evtSrc;
  logic [31:0] evtVector;

  int checks = 0;
  int errors = 0;

  logic [31:0] mPend = '0, mMask = '0, mExc = '0;
  logic [31:0] mVec [32];

  always #2.5 clk = ~clk;

  jump_event_gate #(.RESET_VEC(RST_V), .NMI_VEC(NMI_V)) uut (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .excReq(excReq),
    .nmiReq(nmiReq), .irqIn(irqIn), .jmpValid(jmpValid), .jmpKind(jmpKind),
    .jmpTaken(jmpTaken), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .takeEvt(takeEvt),
    .evtClass(evtClass), .evtSrc(evtSrc), .evtVector(evtVector)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input int a);
    if (a == 0) return mExc;
    if (a == 1) return mPend;
    if (a == 4) return mMask;
    if (a >= 32) return mVec[a-32];
    return '0;
  endfunction

  task automatic idle();
    resetReq = 0; excReq = 0; nmiReq = 0; irqIn = '0;
    jmpValid = 0; jmpKind = '0; jmpTaken = 0;
    regWrEn = 0; regAddr = '0; regWrData = '0;
  endtask

  // reference model: decide from the state before the edge, then apply writes
  task automatic step();
    bit win, eTake;
    logic [1:0] eCls;
    logic [4:0] eSrc;
    logic [31:0] eVec, act, setM, clrM;
    string tag;
    int a;
    win = jmpValid && jmpKind != 2'd0 && jmpTaken;
    act = mPend & mMask;
    eTake = 0; eCls = 0; eSrc = 0; eVec = 0; tag = "R3";
    if (resetReq) begin
      eTake = 1; eVec = RST_V; tag = "R1";
    end else if (win && excReq) begin
      eTake = 1; eCls = 1; eVec = mExc; tag = "R5";
    end else if (win && nmiReq) begin
      eTake = 1; eCls = 2; eVec = NMI_V; tag = "R6";
    end else if (win && act != 0) begin
      eTake = 1; eCls = 3; tag = "R7";
      for (int i = 31; i >= 0; i--) if (act[i]) eSrc = 5'(i);
      eVec = mVec[eSrc];
    end
    setM = '0; clrM = '0;
    a = int'(regAddr);
    if (regWrEn) begin
      if (a == 0) mExc = regWrData;
      if (a == 2) setM = regWrData;
      if (a == 3) clrM = regWrData;
      if (a == 4) mMask = regWrData;
      if (a >= 32) mVec[a-32] = regWrData;
    end
    mPend = (mPend & ~clrM) | irqIn | setM;
    @(posedge clk); #1;
    chk(takeEvt === eTake, tag, "takeEvt", 32'(takeEvt), 32'(eTake));
    chk(evtClass === eCls, tag, "evtClass", 32'(evtClass), 32'(eCls));
    chk(evtSrc === eSrc, tag, "evtSrc", 32'(evtSrc), 32'(eSrc));
    chk(evtVector === eVec, tag, "evtVector", evtVector, eVec);
    chk(regRdData === mRead(a), "R8", "regRdData", regRdData, mRead(a));
    idle();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    regWrEn = 1; regAddr = 6'(a); regWrData = d;
    step();
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    regAddr = 6'(a); #1;
    chk(regRdData === exp, tag, "readback", regRdData, exp);
    regAddr = '0;
  endtask

  task automatic jump(input logic [1:0] k, input bit t);
    jmpValid = 1; jmpKind = k; jmpTaken = t;
  endtask

  task automatic expTake(input logic [1:0] c, input logic [4:0] s,
                         input logic [31:0] v, input string tag);
    chk(takeEvt === 1'b1, tag, "take", 32'(takeEvt), 1);
    chk(evtClass === c, tag, "class", 32'(evtClass), 32'(c));
    chk(evtSrc === s, tag, "src", 32'(evtSrc), 32'(s));
    chk(evtVector === v, tag, "vector", evtVector, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mVec[i] = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R11 reset state
    chk(takeEvt === 1'b0, "R11", "take after reset", 32'(takeEvt), 0);
    rd(0, 0, "R11"); rd(1, 0, "R11"); rd(4, 0, "R11"); rd(45, 0, "R11");

    wr(0, 32'h0000_1000);
    for (int i = 0; i < 32; i++) wr(32 + i, 32'h2000 + 32'(i) * 16);
    wr(4, 32'h0000_0FFF);

    irqIn = 32'h20; step();
    rd(1, 32'h20, "R8");
    jump(2'd0, 1); step();
    chk(takeEvt === 1'b0, "R3", "plain jump", 32'(takeEvt), 0);
    jump(2'd1, 0); step();
    chk(takeEvt === 1'b0, "R3", "untaken jump", 32'(takeEvt), 0);
    jump(2'd2, 1); step();
    expTake(2'd3, 5'd5, 32'h2050, "R2");
    step();
    chk(takeEvt === 1'b0, "R10", "strobe one cycle", 32'(takeEvt), 0);
    rd(1, 32'h20, "R10");

    wr(2, 32'h208);
    jump(2'd3, 1); step();
    expTake(2'd3, 5'd3, 32'h2030, "R7");
    wr(3, 32'h228);
    rd(1, 0, "R9");

    irqIn = 32'h0010_0000; step();
    jump(2'd1, 1); step();
    chk(takeEvt === 1'b0, "R7", "masked source", 32'(takeEvt), 0);
    rd(1, 32'h0010_0000, "R8");

    irqIn = 32'h40; regWrEn = 1; regAddr = 6'd3; regWrData = 32'h40; step();
    rd(1, 32'h0010_0040, "R9");
    wr(3, 0);
    rd(1, 32'h0010_0040, "R9");
    wr(3, 32'h0010_0040);
    rd(1, 0, "R9");

    irqIn = 32'h2; step();
    excReq = 1; nmiReq = 1; jump(2'd1, 1); step();
    expTake(2'd1, 5'd0, 32'h1000, "R4");
    nmiReq = 1; jump(2'd2, 1); step();
    expTake(2'd2, 5'd0, NMI_V, "R6");
    resetReq = 1; excReq = 1; jump(2'd3, 1); step();
    expTake(2'd0, 5'd0, RST_V, "R4");
    resetReq = 1; step();
    expTake(2'd0, 5'd0, RST_V, "R1");
    jump(2'd3, 1); step();
    expTake(2'd3, 5'd1, 32'h2010, "R7");

    excReq = 1; jump(2'd1, 1); step();
    expTake(2'd1, 5'd0, 32'h1000, "R12");
    excReq = 1; jump(2'd2, 1); step();
    expTake(2'd1, 5'd0, 32'h1000, "R12");

    jump(2'd3, 1); regWrEn = 1; regAddr = 6'd33; regWrData = 32'hABC0; step();
    expTake(2'd3, 5'd1, 32'h2010, "R7");
    jump(2'd3, 1); step();
    expTake(2'd3, 5'd1, 32'hABC0, "R7");
    jump(2'd3, 1); regWrEn = 1; regAddr = 6'd3; regWrData = 32'h2; step();
    expTake(2'd3, 5'd1, 32'hABC0, "R9");
    rd(1, 0, "R9");

    for (int n = 0; n < 600; n++) begin
      resetReq = ($urandom_range(0, 19) == 0);
      excReq   = ($urandom_range(0, 5) == 0);
      nmiReq   = ($urandom_range(0, 5) == 0);
      irqIn    = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0;
      jmpValid = $urandom_range(0, 1);
      jmpKind  = 2'($urandom_range(0, 3));
      jmpTaken = $urandom_range(0, 1);
      regWrEn  = ($urandom_range(0, 3) == 0);
      regAddr  = 6'($urandom_range(0, 63));
      regWrData = $urandom;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule